// File: doc/BRIEF.md
# Audio Capture Double-Buffer DMA Controller

This block takes audio samples as they arrive, packs them into 32-bit words, holds them in a small word FIFO and writes them to memory in 64-byte bursts of sixteen words. Software gives it two memory buffers that share one size. The block fills them in turn. When a buffer has been written to its end, its full status bit sets and writing moves to the other buffer. Software empties a full buffer and then returns it to the block by writing 1 to that buffer's acknowledge bit.

There are three capture formats. In 16-bit stereo, each sample is one word. In 32-bit stereo, each sample is two words. In raw byte mode, four successive bytes are packed into each word. The block detects two capture errors and stops sampling on either one. Each error resumes under its own condition and sets its own sticky status bit. A level interrupt is the OR of the status bits, each gated by its enable.

Top module: `audio_cap_dma`

## Requirements
- R1: A burst starts once the FIFO holds at least 16 words and the active buffer is free. `mem_req` stays high with `mem_addr` stable until `mem_gnt`. Then `mem_wvalid` is high for exactly 16 consecutive cycles, one word per cycle. `mem_addr` equals the active buffer base plus the write offset, and the offset steps by 64 bytes per burst.
- R2: With `cfg_mode` = 0 (16-bit stereo), each accepted sample becomes the single word `smp_data[31:0]`, so one burst is written per 16 samples.
- R3: With `cfg_mode` = 1 (32-bit stereo), each accepted sample becomes two words, `smp_data[31:0]` first and then `smp_data[63:32]`, so one burst is written per 8 samples.
- R4: With `cfg_mode` = 2 (raw), byte `smp_data[7:0]` is taken per valid cycle. Byte k (k = 0..3) of each group of four lands in bits 8k+7:8k of the word (little-endian).
- R5: Buffer 1 (`cfg_base1`) is filled first and the buffers then strictly alternate. When the write offset reaches `cfg_size` bytes, the filled buffer's full bit sets (bit 0 for buffer 1, bit 1 for buffer 2) and the offset restarts at 0 in the other buffer.
- R6: If writing switches to a buffer whose full bit is still set, the overrun bit (status bit 3) sets. While that buffer stays full, incoming samples are discarded and no burst is requested. After it is acknowledged, capture resumes and the next burst goes to that buffer's base.
- R7: A sample that arrives when the FIFO lacks room for its words sets the bandwidth-error bit (status bit 2). That sample and all later ones are discarded until the next burst completes.
- R8: `reg_ack` bit i clears status bit i (0 buffer 1 full, 1 buffer 2 full, 2 bandwidth error, 3 overrun). Writing 0 leaves a bit set, so the error bits stay set after capture resumes until they are acknowledged.
- R9: `irq` is high exactly when some status bit and its `reg_int_en` bit are both 1, and it stays high until the cause is acknowledged or the enable bit is dropped.
- R10: After reset, all status bits are 0, `irq` and `mem_req` are low, and buffer 1 at offset 0 is the active buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Capture format: 0 16-bit stereo, 1 32-bit stereo, 2 raw bytes |
| cfg_base1 | input | ADDR_W | Byte address of buffer 1 |
| cfg_base2 | input | ADDR_W | Byte address of buffer 2 |
| cfg_size | input | SIZE_W | Size in bytes of each buffer (nonzero multiple of 64) |
| reg_ack | input | 4 | One-cycle acknowledge strobes, one per status bit |
| reg_int_en | input | 4 | Interrupt enable, one per status bit |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | 64 | Sample data (use depends on mode) |
| mem_req | output | 1 | Burst write request |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_gnt | input | 1 | One-cycle grant of the pending request |
| mem_wvalid | output | 1 | A burst data word is valid |
| mem_wdata | output | 32 | Burst data word |
| status | output | 4 | {overrun, bandwidth error, buffer 2 full, buffer 1 full} |
| irq | output | 1 | Level interrupt |

## Verification
A wrong buffer pointer or a wrong active-buffer choice shows up in the first burst after a buffer switch, as a `mem_addr` outside the expected base plus offset. A FIFO or packing fault shows up in the written word stream, where words are out of order, duplicated or mis-laned within 16 cycles of the grant. Discarding that is wrong, in either direction, shows up as extra or missing words once capture resumes. A flag that is not sticky, or that clears wrongly, shows up on `status` and `irq` in the cycle after the acknowledge write.

// File: rtl/acd_pkg.sv
// Shared constants and types for the audio capture DMA controller.
// Assumes 32-bit memory words and fixed 64-byte bursts.
package acd_pkg;
    localparam int WORD_BYTES  = 4;
    localparam int BURST_BYTES = 64;
    localparam int BURST_WORDS = BURST_BYTES / WORD_BYTES;

    // Status / acknowledge / enable bit positions
    localparam int ST_BUF1 = 0;
    localparam int ST_BUF2 = 1;
    localparam int ST_BWE  = 2;
    localparam int ST_OVR  = 3;

    typedef enum logic [1:0] {
        MODE_S16 = 2'd0,
        MODE_S32 = 2'd1,
        MODE_RAW = 2'd2
    } cap_mode_t;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_REQ  = 2'd1,
        BS_DATA = 2'd2
    } burst_st_t;
endpackage

// File: rtl/acd_packer.sv
// Turns one incoming sample into zero, one or two 32-bit words by mode.
// Raw mode collects bytes little-endian; a group advances only on take.
// Assumes cfg_mode is static while capture runs.
module acd_packer
    import acd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode,
    input  logic [63:0] data,
    input  logic        take,
    output logic [1:0]  push_n,
    output logic [31:0] word0,
    output logic [31:0] word1
);
    logic [1:0]  lane;
    logic [23:0] acc;

    // Word formation and count for the sample on the inputs
    always_comb begin
        word1 = data[63:32];
        case (cap_mode_t'(mode))
            MODE_S32: begin
                push_n = 2'd2;
                word0  = data[31:0];
            end
            MODE_RAW: begin
                push_n = (lane == 2'd3) ? 2'd1 : 2'd0;
                word0  = {data[7:0], acc};
            end
            default: begin
                push_n = 2'd1;
                word0  = data[31:0];
            end
        endcase
    end

    // Raw byte lane tracking and partial word accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane <= 2'd0;
            acc  <= '0;
        end else if (take && cap_mode_t'(mode) == MODE_RAW) begin
            if (lane != 2'd3)
                acc[{lane, 3'b000} +: 8] <= data[7:0];
            lane <= lane + 2'd1;
        end
    end

    assert_raw_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cap_mode_t'(mode) == MODE_RAW && lane == 2'd3) |=> (lane == 2'd0));
endmodule

// File: rtl/acd_fifo.sv
// Word FIFO accepting up to two words per cycle and releasing one.
// Assumes DEPTH is a power of two and the caller never pushes past free.
module acd_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 push_n,
    input  logic [W-1:0]               w0,
    input  logic [W-1:0]               w1,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH):0]     count,
    output logic [$clog2(DEPTH):0]     free
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // Storage write of one or two words
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) store[wr_ptr] <= w0;
        if (push_n == 2'd2) store[wr_ptr + AW'(1)] <= w1;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop);
            count  <= count + CW'(push_n) - CW'(pop);
        end
    end

    assign head = store[rd_ptr];
    assign free = CW'(DEPTH) - count;

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(push_n) <= free);
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/acd_ctrl.sv
// Burst sequencer, buffer alternation, error detection and interrupt.
// Assumes cfg_size is a nonzero multiple of 64 and FIFO depth >= 32 words.
module acd_ctrl
    import acd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base1,
    input  logic [ADDR_W-1:0] base2,
    input  logic [SIZE_W-1:0] size,
    input  logic [3:0]        ack,
    input  logic [3:0]        int_en,
    input  logic              smp_valid,
    input  logic [1:0]        push_n,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [CNT_W-1:0]  fifo_free,
    input  logic              mem_gnt,
    output logic              take,
    output logic              pop,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wvalid,
    output logic [3:0]        status,
    output logic              irq
);
    localparam int BW = $clog2(BURST_WORDS);
    localparam logic [BW-1:0] LAST_BEAT = BW'(BURST_WORDS - 1);

    burst_st_t         state;
    logic [BW-1:0]     beat;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] wptr;
    logic [SIZE_W:0]   next_off;
    logic              active;
    logic [1:0]        full;
    logic              ovr, bwe, bwe_halt;
    logic              active_full, other_busy, cap_halt, room_ok;
    logic              bwe_evt, ovr_evt, burst_done, wrap;
    logic [1:0]        full_set;
    logic [ADDR_W-1:0] base_act;

    // Admission of samples and error event decode
    always_comb begin
        active_full = active ? full[1] : full[0];
        other_busy  = active ? (full[0] & ~ack[ST_BUF1]) : (full[1] & ~ack[ST_BUF2]);
        cap_halt    = active_full | bwe_halt;
        room_ok     = CNT_W'(push_n) <= fifo_free;
        take        = smp_valid & ~cap_halt & room_ok;
        bwe_evt     = smp_valid & ~cap_halt & ~room_ok;
        burst_done  = (state == BS_DATA) && (beat == LAST_BEAT);
        next_off    = {1'b0, wptr} + (SIZE_W + 1)'(BURST_BYTES);
        wrap        = burst_done && (next_off == {1'b0, size});
        ovr_evt     = wrap & other_busy;
        full_set    = wrap ? (active ? 2'b10 : 2'b01) : 2'b00;
        base_act    = active ? base2 : base1;
    end

    // Burst request and data beat sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= BS_IDLE;
            beat   <= '0;
            addr_q <= '0;
        end else begin
            case (state)
                BS_IDLE: if (fifo_count >= CNT_W'(BURST_WORDS) && !active_full) begin
                    state  <= BS_REQ;
                    addr_q <= base_act + ADDR_W'(wptr);
                end
                BS_REQ: if (mem_gnt) begin
                    state <= BS_DATA;
                    beat  <= '0;
                end
                default: begin
                    beat <= beat + BW'(1);
                    if (beat == LAST_BEAT) state <= BS_IDLE;
                end
            endcase
        end
    end

    // Write offset and active buffer alternation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            active <= 1'b0;
        end else if (wrap) begin
            wptr   <= '0;
            active <= ~active;
        end else if (burst_done) begin
            wptr   <= next_off[SIZE_W-1:0];
        end
    end

    // Sticky status flags and bandwidth halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= 2'b00;
            ovr      <= 1'b0;
            bwe      <= 1'b0;
            bwe_halt <= 1'b0;
        end else begin
            full <= (full & ~ack[ST_BUF2:ST_BUF1]) | full_set;
            ovr  <= (ovr & ~ack[ST_OVR]) | ovr_evt;
            bwe  <= (bwe & ~ack[ST_BWE]) | bwe_evt;
            if (bwe_evt)         bwe_halt <= 1'b1;
            else if (burst_done) bwe_halt <= 1'b0;
        end
    end

    assign mem_req    = (state == BS_REQ);
    assign mem_wvalid = (state == BS_DATA);
    assign pop        = mem_wvalid;
    assign mem_addr   = addr_q;
    assign status     = {ovr, bwe, full[1], full[0]};
    assign irq        = |(status & int_en);

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
    assert_burst_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !mem_wvalid);
    assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (active != $past(active)));
    assert_ovr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active_full |-> (!mem_req && !take));
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ack[ST_OVR]) |=> ovr);
    assert_bwe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bwe && !ack[ST_BWE]) |=> bwe);
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack == 4'b0000 && $stable(int_en)) |=> irq);
endmodule

// File: rtl/audio_cap_dma.sv
// Audio capture into two alternating memory buffers by 64-byte bursts.
// Assumes inputs are synchronous to clk and mem_gnt answers only mem_req.
module audio_cap_dma
    import acd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 16,
    parameter int FIFO_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_base1,
    input  logic [ADDR_W-1:0] cfg_base2,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [3:0]        reg_ack,
    input  logic [3:0]        reg_int_en,
    input  logic              smp_valid,
    input  logic [63:0]       smp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    output logic              mem_wvalid,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        status,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    logic             take, pop;
    logic [1:0]       push_n, push_acc;
    logic [31:0]      word0, word1;
    logic [CNT_W-1:0] fifo_count, fifo_free;

    assign push_acc = take ? push_n : 2'd0;

    acd_packer u_pack (
        .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .data(smp_data),
        .take(take), .push_n(push_n), .word0(word0), .word1(word1)
    );

    acd_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_n(push_acc), .w0(word0), .w1(word1),
        .pop(pop), .head(mem_wdata), .count(fifo_count), .free(fifo_free)
    );

    acd_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .base1(cfg_base1), .base2(cfg_base2),
        .size(cfg_size), .ack(reg_ack), .int_en(reg_int_en),
        .smp_valid(smp_valid), .push_n(push_n), .fifo_count(fifo_count),
        .fifo_free(fifo_free), .mem_gnt(mem_gnt), .take(take), .pop(pop),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wvalid(mem_wvalid),
        .status(status), .irq(irq)
    );
endmodule

// File: tb/audio_cap_dma_test.sv
`timescale 1ns/1ps
module audio_cap_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [31:0] cfg_base1 = 32'h0000_1000;
    logic [31:0] cfg_base2 = 32'h0000_2000;
    logic [15:0] cfg_size = 16'd128;
    logic [3:0]  reg_ack = 4'h0;
    logic [3:0]  reg_int_en = 4'h0;
    logic        smp_valid = 1'b0;
    logic [63:0] smp_data = '0;
    logic        mem_req, mem_wvalid, mem_gnt = 1'b0, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  status;

    int vectors = 0, fails = 0;
    bit done = 0, allow = 1;
    logic [31:0] exp_w [256];
    logic [31:0] exp_a [32];
    logic [31:0] got_w [256];
    logic [31:0] got_a [32];
    int ecnt = 0, eacnt = 0, gcnt = 0, gacnt = 0, mbeat = 0, gap_err = 0;
    int cw = 0, ca = 0;

    always #2 clk = ~clk;

    audio_cap_dma uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_base1(cfg_base1),
        .cfg_base2(cfg_base2), .cfg_size(cfg_size), .reg_ack(reg_ack),
        .reg_int_en(reg_int_en), .smp_valid(smp_valid), .smp_data(smp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .status(status), .irq(irq)
    );

    // Memory side: grant model and burst recorder
    always @(negedge clk) begin
        mem_gnt <= mem_req && allow && !mem_gnt;
        if (mem_wvalid) begin
            if (mbeat == 0) begin got_a[gacnt] = mem_addr; gacnt++; end
            got_w[gcnt] = mem_wdata; gcnt++;
            mbeat = (mbeat + 1) % 16;
        end else if (mbeat != 0) gap_err++;
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [1:0] mode);
        rst_n = 1'b0; cfg_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 status", 64'(status), 64'h0);
        chk("R10 req", 64'(mem_req), 64'h0);
        chk("R10 irq", 64'(irq), 64'h0);
    endtask

    task automatic send(logic [63:0] d, int gap);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic ack(logic [3:0] m);
        reg_ack = m;
        @(negedge clk);
        reg_ack = 4'h0;
    endtask

    task automatic exp_burst(logic [31:0] a);
        exp_a[eacnt] = a; eacnt++;
    endtask

    // Compare the recorded stream since the last checkpoint
    task automatic compare(string req);
        chk({req, " word count"}, 64'(gcnt), 64'(ecnt));
        chk({req, " burst count"}, 64'(gacnt), 64'(eacnt));
        for (int i = cw; i < ecnt && i < gcnt; i++) chk({req, " word"}, 64'(got_w[i]), 64'(exp_w[i]));
        for (int i = ca; i < eacnt && i < gacnt; i++) chk("R1 addr", 64'(got_a[i]), 64'(exp_a[i]));
        chk("R1 beat gaps", 64'(gap_err), 64'h0);
        cw = ecnt; ca = eacnt;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        reg_int_en = 4'hF;
        // R2, R5, R6, R8, R9: 16-bit mode, fill both buffers, overrun
        do_reset(2'd0);
        reg_int_en = 4'b0100;
        for (int i = 0; i < 64; i++) begin
            send(64'(32'hA500_0000 + i), 3);
            exp_w[ecnt] = 32'hA500_0000 + i; ecnt++;
        end
        repeat (60) @(negedge clk);
        exp_burst(32'h1000); exp_burst(32'h1040); exp_burst(32'h2000); exp_burst(32'h2040);
        chk("R6 overrun status", 64'(status), 64'b1011);
        chk("R9 masked irq", 64'(irq), 64'h0);
        reg_int_en = 4'b0001;
        @(negedge clk);
        chk("R9 buf1 irq", 64'(irq), 64'h1);
        for (int i = 0; i < 16; i++) send(64'(32'hDEAD_0000 + i), 3);
        repeat (40) @(negedge clk);
        chk("R6 halted req", 64'(mem_req), 64'h0);
        compare("R2");
        reg_int_en = 4'b1000;
        ack(4'b0001);
        chk("R8 buf1 ack", 64'(status), 64'b1010);
        chk("R9 ovr irq", 64'(irq), 64'h1);
        for (int i = 0; i < 16; i++) begin
            send(64'(32'h5A00_0000 + i), 3);
            exp_w[ecnt] = 32'h5A00_0000 + i; ecnt++;
        end
        repeat (40) @(negedge clk);
        exp_burst(32'h1000);
        compare("R6 resume");
        chk("R8 ovr sticky", 64'(status), 64'b1010);
        ack(4'b1000);
        chk("R8 ovr ack", 64'(status), 64'b0010);
        chk("R9 irq cleared", 64'(irq), 64'h0);

        // R3: 32-bit stereo, two words per sample
        do_reset(2'd1);
        for (int i = 0; i < 16; i++) begin
            send({32'hC000_0000 + 32'(i), 32'hD000_0000 + 32'(i)}, 3);
            exp_w[ecnt] = 32'hD000_0000 + i; ecnt++;
            exp_w[ecnt] = 32'hC000_0000 + i; ecnt++;
            if (i == 7) begin
                repeat (30) @(negedge clk);
                chk("R3 one burst per 8", 64'(gacnt - ca), 64'h1);
            end
        end
        repeat (60) @(negedge clk);
        exp_burst(32'h1000); exp_burst(32'h1040);
        compare("R3");
        chk("R5 buf1 full", 64'(status), 64'b0001);

        // R4: raw bytes packed little-endian
        do_reset(2'd2);
        for (int k = 0; k < 64; k++) begin
            logic [7:0] b;
            b = 8'(k * 7 + 3);
            send({56'hFFFF_FFFF_FFFF_FF, b}, 0);
            exp_w[ecnt][(k % 4) * 8 +: 8] = b;
            if (k % 4 == 3) ecnt++;
        end
        repeat (60) @(negedge clk);
        exp_burst(32'h1000);
        compare("R4");

        // R7: bandwidth error with grants withheld
        do_reset(2'd0);
        reg_int_en = 4'b0100;
        allow = 0;
        for (int i = 0; i < 40; i++) begin
            send(64'(32'h7700_0000 + i), 1);
            if (i < 32) begin exp_w[ecnt] = 32'h7700_0000 + i; ecnt++; end
        end
        chk("R7 bwe status", 64'(status), 64'b0100);
        chk("R7 irq", 64'(irq), 64'h1);
        chk("R1 req held", 64'(mem_req), 64'h1);
        chk("R1 addr held", 64'(mem_addr), 64'h1000);
        allow = 1;
        repeat (60) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            send(64'(32'h7800_0000 + i), 3);
            exp_w[ecnt] = 32'h7800_0000 + i; ecnt++;
        end
        repeat (60) @(negedge clk);
        exp_burst(32'h1000); exp_burst(32'h1040); exp_burst(32'h2000);
        compare("R7");
        chk("R8 bwe sticky", 64'(status), 64'b0101);
        ack(4'b0100);
        chk("R8 bwe ack", 64'(status), 64'b0001);
        chk("R9 irq after ack", 64'(irq), 64'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule